// File: doc/BRIEF.md
# Crypto Interrupt Flag Controller

This block holds the interrupt flags of a cipher accelerator. The cipher core sends it single-cycle event pulses: computation done, an unexpected read of the output data register, an unexpected write to the input data register, a key error and a random-source error. The block latches each event as a sticky flag. Software clears a flag by writing 1 to the matching bit of a clear register. The block drives one interrupt line, which is the flags masked by a software-written enable register. The core drives the unexpected access cycles and discards their data. This block only records that they happened.

The read and write access errors each have their own sticky status bit. Both feed one shared access-error flag, and one clear bit removes all three together. When software clears a pending random-source error, the block sends a one-cycle reload request to the random source. The busy and key-valid levels from the core are registered and shown in the status word next to the access-error bits. Bus decoding is outside the block. It sees one write strobe per writable register.

Top module: `crypto_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every flag, the enable register, the status word, `irq` and `rng_reload`.
- R2: Flag positions, shared by the enable, flag and clear words, are: bit 0 done, bit 1 access error, bit 2 key error, bit 3 random-source error. An event pulse sets its flag at the clock edge that samples it. The flag then stays set until it is cleared.
- R3: The access-error flag (bit 1) is set by a read-error pulse, a write-error pulse, or both.
- R4: A clear-register write with a bit at 1 clears that flag at that edge. Bits written 0, and flags not addressed, keep their value.
- R5: A clear write with bit 1 at 1 clears the access-error flag and also both the read-error and write-error status bits.
- R6: When an event and a clear for the same flag arrive in the same cycle, the flag stays set.
- R7: Status word layout: bit 0 copies the done flag, bit 1 is the sticky read error, bit 2 is the sticky write error, bit 3 is busy, bit 7 is key valid. Busy and key valid are sampled one edge after their inputs. All other bits read 0.
- R8: `irq` is a register. At each edge it takes the OR of (new flags AND new enables). A flag or an enable change that lands at an edge shows on `irq` at that same edge.
- R9: `rng_reload` is high for exactly one cycle after an edge at which a set random-source flag is cleared. It stays low when that clear finds the flag already clear, or when a random-source event arrives in the same cycle.
- R10: An enable write stores bits 3:0 of the write data. Enable bits 31:4 and flag bits 31:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_done | input | 1 | Computation done pulse |
| evt_rd_err | input | 1 | Unexpected output-register read pulse |
| evt_wr_err | input | 1 | Unexpected input-register write pulse |
| evt_key_err | input | 1 | Key error pulse |
| evt_rng_err | input | 1 | Random-source error pulse |
| core_busy | input | 1 | Busy level from the core |
| core_key_ok | input | 1 | Key-valid level from the core |
| ien_wr | input | 1 | Enable register write strobe |
| ien_wdata | input | REG_W | Enable register write data |
| clr_wr | input | 1 | Clear register write strobe |
| clr_wdata | input | REG_W | Clear register write data, 1 clears |
| ien_q | output | REG_W | Enable register value |
| isr_q | output | REG_W | Flag register value |
| sr_q | output | REG_W | Status word |
| irq | output | 1 | Combined masked interrupt |
| rng_reload | output | 1 | One-cycle random reload request |

## Verification
Every result is one register stage behind its stimulus. Flags, status bits, enables, `irq` and `rng_reload` all change at the first rising edge that samples the pulse or write, and busy and key valid follow the same rule. The bench changes inputs on the falling edge and reads all outputs on the next falling edge, so each check falls exactly one edge after its stimulus. The check one row later confirms that `rng_reload` has dropped again.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
  localparam int NFLAG    = 4;
  // flag positions in enable, flag and clear words
  localparam int F_DONE   = 0;
  localparam int F_ACCERR = 1;
  localparam int F_KEYERR = 2;
  localparam int F_RNGERR = 3;
  // status word positions
  localparam int S_DONE   = 0;
  localparam int S_RDERR  = 1;
  localparam int S_WRERR  = 2;
  localparam int S_BUSY   = 3;
  localparam int S_KEYOK  = 7;
  localparam int S_MINW   = S_KEYOK + 1;
endpackage

// File: rtl/cirq_flag_bank.sv
module cirq_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flag_d,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    // set has priority over a same-cycle clear
    assign flag_d[i] = set_i[i] | (flag_q[i] & ~(clr_wr & clr_mask[i]));

    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= flag_d[i];
    end
  end
endmodule

// File: rtl/cirq_irq_merge.sv
module cirq_irq_merge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flag_d,
  input  logic [N-1:0] ien_d,
  output logic         irq_q
);
  logic [N-1:0] masked;
  assign masked = flag_d & ien_d;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |masked;
  end
endmodule

// File: rtl/cirq_status_pack.sv
module cirq_status_pack
  import cirq_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_rd,
  input  logic             evt_wr,
  input  logic             acc_clr,
  input  logic             busy_in,
  input  logic             key_ok_in,
  input  logic             done_flag,
  output logic [REG_W-1:0] sr_q
);
  logic rd_q, wr_q, busy_q, key_ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      busy_q   <= 1'b0;
      key_ok_q <= 1'b0;
    end else begin
      rd_q     <= evt_rd | (rd_q & ~acc_clr);
      wr_q     <= evt_wr | (wr_q & ~acc_clr);
      busy_q   <= busy_in;
      key_ok_q <= key_ok_in;
    end
  end

  always_comb begin
    sr_q          = '0;
    sr_q[S_DONE]  = done_flag;
    sr_q[S_RDERR] = rd_q;
    sr_q[S_WRERR] = wr_q;
    sr_q[S_BUSY]  = busy_q;
    sr_q[S_KEYOK] = key_ok_q;
  end
endmodule

// File: rtl/crypto_irq_ctrl.sv
module crypto_irq_ctrl
  import cirq_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_done,
  input  logic             evt_rd_err,
  input  logic             evt_wr_err,
  input  logic             evt_key_err,
  input  logic             evt_rng_err,
  input  logic             core_busy,
  input  logic             core_key_ok,
  input  logic             ien_wr,
  input  logic [REG_W-1:0] ien_wdata,
  input  logic             clr_wr,
  input  logic [REG_W-1:0] clr_wdata,
  output logic [REG_W-1:0] ien_q,
  output logic [REG_W-1:0] isr_q,
  output logic [REG_W-1:0] sr_q,
  output logic             irq,
  output logic             rng_reload
);
  localparam int PADW = REG_W - NFLAG;

  logic [NFLAG-1:0] set_vec, clr_mask, flag_d, flag_q, ien_d, ien_r;
  logic             reload_q;
  logic             unused_hi;

  assign unused_hi = ^{clr_wdata[REG_W-1:NFLAG], ien_wdata[REG_W-1:NFLAG]};

  always_comb begin
    set_vec           = '0;
    set_vec[F_DONE]   = evt_done;
    set_vec[F_ACCERR] = evt_rd_err | evt_wr_err;
    set_vec[F_KEYERR] = evt_key_err;
    set_vec[F_RNGERR] = evt_rng_err;
  end

  assign clr_mask = clr_wdata[NFLAG-1:0];

  cirq_flag_bank #(.N(NFLAG)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .set_i    (set_vec),
    .clr_wr   (clr_wr),
    .clr_mask (clr_mask),
    .flag_d   (flag_d),
    .flag_q   (flag_q)
  );

  assign ien_d = ien_wr ? ien_wdata[NFLAG-1:0] : ien_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_r    <= '0;
      reload_q <= 1'b0;
    end else begin
      ien_r    <= ien_d;
      reload_q <= clr_wr & clr_mask[F_RNGERR] & flag_q[F_RNGERR] & ~evt_rng_err;
    end
  end

  cirq_irq_merge #(.N(NFLAG)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .flag_d (flag_d),
    .ien_d  (ien_d),
    .irq_q  (irq)
  );

  cirq_status_pack #(.REG_W(REG_W)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .evt_rd    (evt_rd_err),
    .evt_wr    (evt_wr_err),
    .acc_clr   (clr_wr & clr_mask[F_ACCERR]),
    .busy_in   (core_busy),
    .key_ok_in (core_key_ok),
    .done_flag (flag_q[F_DONE]),
    .sr_q      (sr_q)
  );

  assign ien_q      = {{PADW{1'b0}}, ien_r};
  assign isr_q      = {{PADW{1'b0}}, flag_q};
  assign rng_reload = reload_q;
endmodule

// File: rtl/cirq_checker.sv
module cirq_checker #(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             evt_done,
  input logic             evt_rd_err,
  input logic             evt_wr_err,
  input logic             evt_key_err,
  input logic             evt_rng_err,
  input logic             ien_wr,
  input logic [REG_W-1:0] ien_wdata,
  input logic             clr_wr,
  input logic [REG_W-1:0] clr_wdata,
  input logic [REG_W-1:0] ien_q,
  input logic [REG_W-1:0] isr_q,
  input logic [REG_W-1:0] sr_q,
  input logic             irq,
  input logic             rng_reload
);
  p_done_set_r2: assert property (@(posedge clk) disable iff (rst)
    evt_done |=> isr_q[0]);

  p_acc_set_r3: assert property (@(posedge clk) disable iff (rst)
    (evt_rd_err || evt_wr_err) |=> isr_q[1]);

  p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (isr_q[2] && !(clr_wr && clr_wdata[2])) |=> isr_q[2]);

  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && clr_wdata[0] && !evt_done) |=> !isr_q[0]);

  p_acc_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && clr_wdata[1] && !evt_rd_err && !evt_wr_err)
      |=> (!isr_q[1] && !sr_q[1] && !sr_q[2]));

  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (evt_key_err && clr_wr && clr_wdata[2]) |=> isr_q[2]);

  p_mirror_r7: assert property (@(posedge clk) disable iff (rst)
    sr_q[0] == isr_q[0]);

  p_irq_r8: assert property (@(posedge clk) disable iff (rst)
    irq == |(isr_q[3:0] & ien_q[3:0]));

  p_reload_cause_r9: assert property (@(posedge clk) disable iff (rst)
    rng_reload |-> ($past(isr_q[3]) && !isr_q[3]));

  p_reload_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rng_reload |=> !rng_reload);

  p_ien_write_r10: assert property (@(posedge clk) disable iff (rst)
    ien_wr |=> ien_q[3:0] == $past(ien_wdata[3:0]));
endmodule

bind crypto_irq_ctrl cirq_checker #(.REG_W(REG_W)) u_cirq_checker (
  .clk         (clk),
  .rst         (rst),
  .evt_done    (evt_done),
  .evt_rd_err  (evt_rd_err),
  .evt_wr_err  (evt_wr_err),
  .evt_key_err (evt_key_err),
  .evt_rng_err (evt_rng_err),
  .ien_wr      (ien_wr),
  .ien_wdata   (ien_wdata),
  .clr_wr      (clr_wr),
  .clr_wdata   (clr_wdata),
  .ien_q       (ien_q),
  .isr_q       (isr_q),
  .sr_q        (sr_q),
  .irq         (irq),
  .rng_reload  (rng_reload)
);

// File: tb/crypto_irq_ctrl_test.sv
module crypto_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_done = 0, evt_rd_err = 0, evt_wr_err = 0, evt_key_err = 0, evt_rng_err = 0;
  logic        core_busy = 0, core_key_ok = 0;
  logic        ien_wr = 0, clr_wr = 0;
  logic [31:0] ien_wdata = '0, clr_wdata = '0;
  logic [31:0] ien_q, isr_q, sr_q;
  logic        irq, rng_reload;

  int checks = 0;
  int fails  = 0;
  bit over   = 0;

  always #5 clk = ~clk;

  crypto_irq_ctrl #(.REG_W(32)) uut (
    .clk(clk), .rst(rst),
    .evt_done(evt_done), .evt_rd_err(evt_rd_err), .evt_wr_err(evt_wr_err),
    .evt_key_err(evt_key_err), .evt_rng_err(evt_rng_err),
    .core_busy(core_busy), .core_key_ok(core_key_ok),
    .ien_wr(ien_wr), .ien_wdata(ien_wdata), .clr_wr(clr_wr), .clr_wdata(clr_wdata),
    .ien_q(ien_q), .isr_q(isr_q), .sr_q(sr_q), .irq(irq), .rng_reload(rng_reload)
  );

  typedef struct packed {
    logic [4:0] evt;   // {rng, key, wr, rd, done}
    logic       ienw;
    logic [3:0] iend;
    logic       clrw;
    logic [3:0] clrd;
    logic       busy;
    logic       kok;
    logic [3:0] xisr;
    logic [7:0] xsr;
    logic       xirq;
    logic       xrel;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{5'b00001, 1'b0, 4'h0, 1'b0, 4'h0, 1'b0, 1'b0, 4'h1, 8'h01, 1'b0, 1'b0}, // R2 done sets
    '{5'b00000, 1'b1, 4'h1, 1'b0, 4'h0, 1'b0, 1'b0, 4'h1, 8'h01, 1'b1, 1'b0}, // R8 enable raises irq
    '{5'b00010, 1'b0, 4'h0, 1'b0, 4'h0, 1'b0, 1'b0, 4'h3, 8'h03, 1'b1, 1'b0}, // R3 read error
    '{5'b00000, 1'b0, 4'h0, 1'b1, 4'h1, 1'b0, 1'b0, 4'h2, 8'h02, 1'b0, 1'b0}, // R4 clear done
    '{5'b00100, 1'b0, 4'h0, 1'b1, 4'h0, 1'b0, 1'b0, 4'h2, 8'h06, 1'b0, 1'b0}, // R4 zero clear, write error
    '{5'b00000, 1'b0, 4'h0, 1'b1, 4'h2, 1'b0, 1'b0, 4'h0, 8'h00, 1'b0, 1'b0}, // R5 access clear
    '{5'b01000, 1'b1, 4'h4, 1'b0, 4'h0, 1'b0, 1'b0, 4'h4, 8'h00, 1'b1, 1'b0}, // R8 key err + enable
    '{5'b01000, 1'b0, 4'h0, 1'b1, 4'h4, 1'b0, 1'b0, 4'h4, 8'h00, 1'b1, 1'b0}, // R6 set wins
    '{5'b10000, 1'b0, 4'h0, 1'b0, 4'h0, 1'b1, 1'b1, 4'hC, 8'h88, 1'b1, 1'b0}, // R7 busy, key ok
    '{5'b00000, 1'b1, 4'h8, 1'b1, 4'h4, 1'b1, 1'b1, 4'h8, 8'h88, 1'b1, 1'b0}, // R8 enable swap
    '{5'b10000, 1'b0, 4'h0, 1'b1, 4'h8, 1'b1, 1'b1, 4'h8, 8'h88, 1'b1, 1'b0}, // R9 no reload on set-wins
    '{5'b00000, 1'b0, 4'h0, 1'b1, 4'h8, 1'b0, 1'b1, 4'h0, 8'h80, 1'b0, 1'b1}, // R9 reload pulse
    '{5'b00000, 1'b0, 4'h0, 1'b1, 4'h8, 1'b0, 1'b1, 4'h0, 8'h80, 1'b0, 1'b0}, // R9 no reload, flag clear
    '{5'b11111, 1'b1, 4'hF, 1'b0, 4'h0, 1'b0, 1'b1, 4'hF, 8'h87, 1'b1, 1'b0}, // R2 all events
    '{5'b00000, 1'b0, 4'h0, 1'b1, 4'hF, 1'b0, 1'b1, 4'h0, 8'h80, 1'b0, 1'b1}  // R5 clear all
  };
  localparam int VREQ [NV] = '{2, 8, 3, 4, 4, 5, 8, 6, 7, 8, 9, 9, 9, 2, 5};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    {evt_rng_err, evt_key_err, evt_wr_err, evt_rd_err, evt_done} = '0;
    ien_wr = 0; clr_wr = 0; ien_wdata = '0; clr_wdata = '0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    if (!over) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 isr", isr_q, 32'h0);
    chk("R1 ien", ien_q, 32'h0);
    chk("R1 sr", sr_q, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 reload", {31'h0, rng_reload}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      {evt_rng_err, evt_key_err, evt_wr_err, evt_rd_err, evt_done} = VEC[v].evt;
      ien_wr      = VEC[v].ienw;
      ien_wdata   = {28'h0, VEC[v].iend};
      clr_wr      = VEC[v].clrw;
      clr_wdata   = {28'h0, VEC[v].clrd};
      core_busy   = VEC[v].busy;
      core_key_ok = VEC[v].kok;
      @(negedge clk);
      chk($sformatf("R%0d vec%0d isr", VREQ[v], v), isr_q, {28'h0, VEC[v].xisr});
      chk($sformatf("R%0d vec%0d sr", VREQ[v], v), sr_q, {24'h0, VEC[v].xsr});
      chk($sformatf("R%0d vec%0d irq", VREQ[v], v), {31'h0, irq}, {31'h0, VEC[v].xirq});
      chk($sformatf("R%0d vec%0d reload", VREQ[v], v), {31'h0, rng_reload}, {31'h0, VEC[v].xrel});
    end
    idle_inputs();

    // R10 enable write keeps only bits 3:0
    ien_wr = 1; ien_wdata = 32'hFFFF_FFF5;
    @(negedge clk);
    idle_inputs();
    chk("R10 ien upper", ien_q, 32'h0000_0005);
    evt_key_err = 1; evt_done = 1;
    @(negedge clk);
    idle_inputs();
    chk("R10 isr upper", isr_q, 32'h0000_0005);
    chk("R8 irq masked set", {31'h0, irq}, 32'h1);

    // R1 reset in mid-run with flags and enables set
    evt_rng_err = 1; core_busy = 1;
    @(negedge clk);
    idle_inputs();
    rst = 1;
    @(negedge clk);
    chk("R1 mid isr", isr_q, 32'h0);
    chk("R1 mid ien", ien_q, 32'h0);
    chk("R1 mid sr", sr_q, 32'h0);
    chk("R1 mid irq", {31'h0, irq}, 32'h0);
    rst = 0;
    core_busy = 0; core_key_ok = 0;
    @(negedge clk);
    over = 1;
    report();
  end
endmodule